// File: doc/BRIEF.md
# Pointer-Based Memory Delay Line

This block delays a data stream by a fixed number of cycles set by a power-of-two depth parameter. It does not push samples through a chain of flip-flops. Each sample is written once into a two-port storage array and stays there. Two wrapping address counters walk the array: one for writing and one for reading. Each advancing cycle therefore costs one array write and one array read, whatever the depth.

The read counter is always one entry ahead of the write counter. Each location is therefore read just before it is overwritten, which means exactly one full lap of the array after it was written. The array read is registered, and a second output register follows it. The total delay equals the depth.

A valid flag marks the output as meaningful once the array has been filled after reset. An optional advance input, chosen by a parameter, stalls the whole line when it is low. When the parameter removes it, the line advances on every clock.

Top module: `ptr_delay_line`

## Requirements
- R1: While the synchronous reset is high, and directly after it is released, `dout` is zero and `dout_vld` is low. Internally, reset sets the read address to 0 and the write address to DEPTH-1.
- R2: On every advancing clock edge, both address counters step by one and wrap from DEPTH-1 to 0.
- R3: The read address always equals the write address plus one, modulo DEPTH. A location is never read and written in the same cycle, so a read returns contents written one full lap earlier.
- R4: After an advancing edge, `dout` carries the `din` value that was sampled DEPTH advancing edges earlier.
- R5: `dout_vld` stays low for the first DEPTH advancing edges after reset. It rises after the next advancing edge and then stays high until reset.
- R6: With HAS_ENABLE=1 and `en` low at an edge, nothing is written, both counters hold, and `dout` and `dout_vld` keep their values.
- R7: A stall of any length loses no stored sample. After `en` returns high, the output continues the delayed stream exactly, with the delay counted in advancing edges only.
- R8: With HAS_ENABLE=0, `en` is ignored and the line advances on every clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; used only when HAS_ENABLE=1 |
| din | input | DATA_W | Sample entering the line |
| dout | output | DATA_W | Sample delayed by DEPTH advancing edges |
| dout_vld | output | 1 | High once the output carries a real sample |

## Verification
A sample presented at an advancing edge is due on `dout` after the DEPTH-th advancing edge that follows it. A stalled edge moves nothing: it neither delays the sample further in advancing edges nor changes the outputs, and `dout_vld` changes only on the edge that completes the fill. The bench keeps a queue of the samples taken on advancing edges and drives inputs on the falling edge. It compares both outputs half a cycle after each rising edge, so every expected value refers to the edge that has just occurred. A second instance without the enable checks the same timing with every edge counted.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pdl_addr_ctr.sv
module pdl_addr_ctr #(
   parameter int unsigned    AW       = 4,
   parameter logic [AW-1:0]  INIT_VAL = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [AW-1:0] addr
);

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (rst)
         addr_q <= INIT_VAL;
      else if (adv)
         addr_q <= addr_q + 1'b1;
   end

   assign addr = addr_q;

   // R2
   ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
      adv |=> (addr_q == $past(addr_q) + 1'b1));

   // R6
   ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(addr_q));

endmodule

// File: rtl/pdl_tp_ram.sv
module pdl_tp_ram #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rd_en)
         rd_q <= mem[rd_addr];
   end

   assign rd_data = rd_q;

   // R3
   no_collide_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && rd_en) |-> (wr_addr != rd_addr));

endmodule

// File: rtl/pdl_fill_tracker.sv
module pdl_fill_tracker #(
   parameter int unsigned AW = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic full
);

   logic [AW:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (adv && !cnt_q[AW])
         cnt_q <= cnt_q + 1'b1;
   end

   assign full = cnt_q[AW];

   // R5
   fill_sat_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q[AW] |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/ptr_delay_line.sv
module ptr_delay_line #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned DEPTH      = 16,
   parameter bit          HAS_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_vld
);

   localparam int unsigned   AW      = $clog2(DEPTH);
   localparam logic [AW-1:0] RD_INIT = '0;
   localparam logic [AW-1:0] WR_INIT = {AW{1'b1}};

   if (!pdl_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("ptr_delay_line: DEPTH must be a power of two and at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("ptr_delay_line: DATA_W must be at least 1");
   end

   logic              adv;
   logic [AW-1:0]     wr_addr;
   logic [AW-1:0]     rd_addr;
   logic [DATA_W-1:0] ram_q;
   logic              fill_full;
   logic [DATA_W-1:0] dout_q;
   logic              vld_q;

   if (HAS_ENABLE) begin : g_gated
      assign adv = en;

      // R6
      stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
         !en |=> ($stable(dout_q) && $stable(vld_q)));
   end else begin : g_free
      assign adv = 1'b1;
   end

   pdl_addr_ctr #(.AW(AW), .INIT_VAL(WR_INIT)) u_wr_ctr (
      .clk  (clk),
      .rst  (rst),
      .adv  (adv),
      .addr (wr_addr)
   );

   pdl_addr_ctr #(.AW(AW), .INIT_VAL(RD_INIT)) u_rd_ctr (
      .clk  (clk),
      .rst  (rst),
      .adv  (adv),
      .addr (rd_addr)
   );

   pdl_tp_ram #(.DW(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (adv),
      .wr_addr (wr_addr),
      .wr_data (din),
      .rd_en   (adv),
      .rd_addr (rd_addr),
      .rd_data (ram_q)
   );

   pdl_fill_tracker #(.AW(AW)) u_fill (
      .clk  (clk),
      .rst  (rst),
      .adv  (adv),
      .full (fill_full)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dout_q <= '0;
         vld_q  <= 1'b0;
      end else if (adv) begin
         dout_q <= ram_q;
         vld_q  <= fill_full;
      end
   end

   assign dout     = dout_q;
   assign dout_vld = vld_q;

   // R3
   ptr_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_addr - wr_addr) == AW'(1));

   // R5
   vld_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      vld_q |=> vld_q);

endmodule

// File: tb/tb_ptr_delay_line.sv
module tb_ptr_delay_line;

   localparam int unsigned DW = 8;
   localparam int unsigned D  = 16;
   localparam time         CLK_P = 10ns;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en  = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout, dout_f;
   logic          vld, vld_f;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;
   bit stall_seen = 0;

   int q_gate[$];
   int q_free[$];

   always #(CLK_P/2) clk = ~clk;

   ptr_delay_line #(.DATA_W(DW), .DEPTH(D), .HAS_ENABLE(1'b1)) dut (
      .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout), .dout_vld(vld)
   );

   ptr_delay_line #(.DATA_W(DW), .DEPTH(D), .HAS_ENABLE(1'b0)) dut_free (
      .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout_f), .dout_vld(vld_f)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic [DW-1:0] d, input logic e);
      bit ev;
      din = d;
      en  = e;
      @(posedge clk);
      @(negedge clk);
      if (rst) begin
         q_gate.delete();
         q_free.delete();
         stall_seen = 0;
         chk(dout == '0, "R1 dout after reset", int'(dout), 0);
         chk(vld == 1'b0, "R1 valid after reset", int'(vld), 0);
         chk(dout_f == '0, "R1 free dout after reset", int'(dout_f), 0);
         chk(vld_f == 1'b0, "R1 free valid after reset", int'(vld_f), 0);
      end else begin
         if (e) begin
            q_gate.push_back(int'(d));
            if (q_gate.size() > D + 1) void'(q_gate.pop_front());
         end
         q_free.push_back(int'(d));
         if (q_free.size() > D + 1) void'(q_free.pop_front());

         ev = (q_gate.size() == D + 1);
         chk(vld == ev, e ? "R5 valid" : "R6 valid hold", int'(vld), int'(ev));
         if (ev) begin
            if (!e)
               chk(int'(dout) == q_gate[0], "R6 dout hold", int'(dout), q_gate[0]);
            else if (stall_seen)
               chk(int'(dout) == q_gate[0], "R7 resume after stall", int'(dout), q_gate[0]);
            else
               chk(int'(dout) == q_gate[0], "R4 delay (R2 R3)", int'(dout), q_gate[0]);
         end
         if (!e) stall_seen = 1;

         ev = (q_free.size() == D + 1);
         chk(vld_f == ev, "R8 free valid", int'(vld_f), int'(ev));
         if (ev)
            chk(int'(dout_f) == q_free[0], "R8 free delay", int'(dout_f), q_free[0]);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      step('0, 1'b1);
      step('0, 1'b1);
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R4 R5: ramp through fill and several laps
      for (int i = 0; i < 40; i++) step(DW'(i + 1), 1'b1);
      // R6 R7: random data with random stalls
      for (int i = 0; i < 120; i++) step(DW'($urandom), ($urandom % 10) < 7);
      // R6: long stall
      for (int i = 0; i < 20; i++) step(DW'($urandom), 1'b0);
      // R7: alternating pattern after stall
      for (int i = 0; i < 40; i++) step((i % 2) ? 8'hAA : 8'h55, 1'b1);
      // R1: reset mid-stream, then refill with stalls during fill
      do_reset();
      for (int i = 0; i < 60; i++) step(DW'(8'hF0 ^ i), (i % 3) != 1);
      for (int i = 0; i < 40; i++) step(DW'($urandom), 1'b1);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule